// File: doc/BRIEF.md
# Capture and Up/Down Auto-Reload Timer

A 16-bit timer/counter paired with a 16-bit reload/capture register. Each count step comes from one of two sources. The first is an internal machine-cycle tick. The second is a falling edge on an external count pin, after that pin has passed through a synchroniser. A second external pin, the control pin, has three uses that depend on the mode: in capture mode its falling edge latches the count, in plain auto-reload mode its falling edge forces a reload, and in up/down mode its level sets the counting direction.

Software reaches the block through plain register strobes. It can write the count, write the reload register, read both values, and clear the two sticky flags. The flags are an overflow/underflow flag and an external-event flag. A combined interrupt request is also provided.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count, the reload register, both flags and the interrupt request are all 0.
- R2: With `ext_src_i`=0, a cycle with `tick_i`=1 is one count step. With `ext_src_i`=1, each synchronised falling edge of `cnt_pin_i` is one count step, and `tick_i` is ignored.
- R3: Counting up from FFFFh is an overflow, and it sets the overflow flag. In capture mode the count then wraps to 0000h. In auto-reload mode it loads the reload register instead.
- R4: In capture mode with `ext_en_i`=1, a falling edge on the control pin copies the current count into the reload register and sets the external flag. With `ext_en_i`=0 the edge changes neither.
- R5: In auto-reload mode with `updn_en_i`=0 and `ext_en_i`=1, a falling edge on the control pin loads the count from the reload register and sets the external flag.
- R6: In auto-reload mode with `updn_en_i`=1, the timer counts up while the synchronised control pin is 1 and down while it is 0. When a down step finds the count equal to the reload register, that is an underflow: the count loads FFFFh and the overflow flag is set.
- R7: In up/down mode each overflow or underflow toggles the external flag. `irq_o` is the overflow flag ORed with the external flag, but the external flag is left out of `irq_o` while up/down mode is selected.
- R8: Both flags stay set until their own clear strobe. When a setting event and a clear strobe fall in the same cycle, the flag ends up set.
- R9: A count write takes priority over a count step and over a forced reload in the same cycle. A reload write takes priority over a capture in the same cycle. Each written value is readable one cycle later.
- R10: Both pins pass through two synchroniser flops. A falling edge is recognised only when a synchronised 1 sample is followed by a synchronised 0 sample. Its effect shows on the outputs three clock edges after the first edge that samples the low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle tick (internal count source) |
| ext_src_i | input | 1 | 1: count pin edges; 0: tick |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| ctl_pin_i | input | 1 | External control pin (asynchronous) |
| cap_mode_i | input | 1 | 1: capture mode; 0: auto-reload mode |
| ext_en_i | input | 1 | Enables control-pin edge actions |
| updn_en_i | input | 1 | Up/down enable (auto-reload mode only) |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | 16 | Reload register write data |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| ext_clr_i | input | 1 | External flag clear strobe |
| cnt_o | output | 16 | Current count |
| rld_o | output | 16 | Reload/capture register |
| ovf_flag_o | output | 1 | Overflow/underflow flag |
| ext_flag_o | output | 1 | External-event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Three kinds of result have different latencies:

- Register writes, tick-driven steps and flag changes show one clock edge after the cycle that causes them.
- Pin-driven actions (count steps, captures, forced reloads, direction changes) show three edges after the first edge that samples the new pin level.
- `irq_o` follows the mode inputs within the same cycle.

The bench drives inputs on the falling clock edge. Its behavioural model is stepped on each rising edge, with pin history kept as sample queues. Every output is compared a quarter period after that rising edge, so each result is checked in exactly the cycle where it is due.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int DEF_WIDTH = 16;
    localparam int DEF_SYNC  = 2;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_UP,
        ACT_DOWN,
        ACT_LOAD
    } cnt_act_e;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
    parameter int STAGES = crt_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_q, sh_d;
    logic              prev_q, prev_d;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], pin_i};
        end else begin : g_single
            always_comb sh_d = pin_i;
        end
    endgenerate

    always_comb prev_d = sh_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign lvl_o  = sh_q[LAST];
    assign fall_o = prev_q & ~sh_q[LAST];

    // R10: a recognised edge is a single-cycle pulse
    a_r10_fall_single : assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/crt_engine.sv
module crt_engine
    import crt_pkg::*;
#(
    parameter int WIDTH = crt_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             ctl_fall_i,
    input  logic             ctl_lvl_i,
    input  logic             cap_mode_i,
    input  logic             ext_en_i,
    input  logic             updn_en_i,
    input  logic             cnt_wr_i,
    input  logic [WIDTH-1:0] cnt_wdata_i,
    input  logic             rld_wr_i,
    input  logic [WIDTH-1:0] rld_wdata_i,
    input  logic             ovf_clr_i,
    input  logic             ext_clr_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] rld_o,
    output logic             ovf_o,
    output logic             ext_o,
    output logic             irq_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] rld;
        logic             ovf;
        logic             ext;
    } state_t;

    state_t   st_q, st_d;
    cnt_act_e act;
    logic     ud_mode, frc_rld, cap_evt, wrap_evt, ext_base;
    logic [WIDTH-1:0] load_val;

    always_comb begin
        ud_mode  = ~cap_mode_i & updn_en_i;
        frc_rld  = ~cap_mode_i & ~updn_en_i & ext_en_i & ctl_fall_i;
        cap_evt  = cap_mode_i & ext_en_i & ctl_fall_i;
        wrap_evt = 1'b0;
        load_val = st_q.rld;
        act      = ACT_HOLD;

        if (cnt_wr_i) begin
            act      = ACT_LOAD;
            load_val = cnt_wdata_i;
        end else if (frc_rld) begin
            act      = ACT_LOAD;
            load_val = st_q.rld;
        end else if (step_i) begin
            if (!ud_mode || ctl_lvl_i) begin
                if (st_q.cnt == ALL_ONES) begin
                    wrap_evt = 1'b1;
                    act      = ACT_LOAD;
                    load_val = cap_mode_i ? '0 : st_q.rld;
                end else begin
                    act = ACT_UP;
                end
            end else begin
                if (st_q.cnt == st_q.rld) begin
                    wrap_evt = 1'b1;
                    act      = ACT_LOAD;
                    load_val = ALL_ONES;
                end else begin
                    act = ACT_DOWN;
                end
            end
        end

        st_d = st_q;
        unique case (act)
            ACT_UP:   st_d.cnt = st_q.cnt + 1'b1;
            ACT_DOWN: st_d.cnt = st_q.cnt - 1'b1;
            ACT_LOAD: st_d.cnt = load_val;
            default:  st_d.cnt = st_q.cnt;
        endcase

        if (rld_wr_i)     st_d.rld = rld_wdata_i;
        else if (cap_evt) st_d.rld = st_q.cnt;

        st_d.ovf = (st_q.ovf & ~ovf_clr_i) | wrap_evt;
        ext_base = st_q.ext & ~ext_clr_i;
        if (ud_mode) st_d.ext = ext_base ^ wrap_evt;
        else         st_d.ext = ext_base | cap_evt | frc_rld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign rld_o = st_q.rld;
    assign ovf_o = st_q.ovf;
    assign ext_o = st_q.ext;
    assign irq_o = st_q.ovf | (st_q.ext & ~ud_mode);

    // R9: a count write lands regardless of stepping
    a_r9_write_wins : assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> cnt_o == $past(cnt_wdata_i));
    // R3: up overflow in capture mode wraps to zero and flags
    a_r3_cap_wrap : assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && cap_mode_i && !cnt_wr_i && cnt_o == ALL_ONES)
        |=> (cnt_o == '0) && ovf_o);
    // R6: down step at the reload value loads all ones
    a_r6_underflow : assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cap_mode_i && updn_en_i && !ctl_lvl_i && !cnt_wr_i
         && cnt_o == rld_o) |=> (cnt_o == ALL_ONES) && ovf_o);
    // R4: a capture copies the count
    a_r4_capture : assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode_i && ext_en_i && ctl_fall_i && !rld_wr_i)
        |=> (rld_o == $past(cnt_o)) && ext_o);
    // R8: flags hold without a clear
    a_r8_ovf_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !ovf_clr_i) |=> ovf_o);
    // R7: up/down wrap toggles the external flag
    a_r7_ext_toggle : assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cap_mode_i && updn_en_i && ctl_lvl_i && !cnt_wr_i
         && !ext_clr_i && cnt_o == ALL_ONES) |=> ext_o != $past(ext_o));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
    parameter int WIDTH       = crt_pkg::DEF_WIDTH,
    parameter int SYNC_STAGES = crt_pkg::DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ext_src_i,
    input  logic             cnt_pin_i,
    input  logic             ctl_pin_i,
    input  logic             cap_mode_i,
    input  logic             ext_en_i,
    input  logic             updn_en_i,
    input  logic             cnt_wr_i,
    input  logic [WIDTH-1:0] cnt_wdata_i,
    input  logic             rld_wr_i,
    input  logic [WIDTH-1:0] rld_wdata_i,
    input  logic             ovf_clr_i,
    input  logic             ext_clr_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] rld_o,
    output logic             ovf_flag_o,
    output logic             ext_flag_o,
    output logic             irq_o
);
    logic cnt_lvl, cnt_fall, ctl_lvl, ctl_fall, step;

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i),
        .lvl_o(cnt_lvl), .fall_o(cnt_fall)
    );

    crt_edge_sync #(.STAGES(SYNC_STAGES)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(ctl_pin_i),
        .lvl_o(ctl_lvl), .fall_o(ctl_fall)
    );

    assign step = ext_src_i ? cnt_fall : tick_i;

    crt_engine #(.WIDTH(WIDTH)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .step_i(step), .ctl_fall_i(ctl_fall), .ctl_lvl_i(ctl_lvl),
        .cap_mode_i(cap_mode_i), .ext_en_i(ext_en_i), .updn_en_i(updn_en_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i),
        .ovf_clr_i(ovf_clr_i), .ext_clr_i(ext_clr_i),
        .cnt_o(cnt_o), .rld_o(rld_o), .ovf_o(ovf_flag_o),
        .ext_o(ext_flag_o), .irq_o(irq_o)
    );

    // R2: the level of the count pin only matters through its edges
    logic unused_lvl;
    assign unused_lvl = cnt_lvl;
endmodule

// File: tb/cap_reload_timer_bench.sv
module cap_reload_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 0, ext_src_i = 0, cnt_pin_i = 1, ctl_pin_i = 1;
    logic        cap_mode_i = 1, ext_en_i = 0, updn_en_i = 0;
    logic        cnt_wr_i = 0, rld_wr_i = 0, ovf_clr_i = 0, ext_clr_i = 0;
    logic [15:0] cnt_wdata_i = 0, rld_wdata_i = 0;
    logic [15:0] cnt_o, rld_o;
    logic        ovf_flag_o, ext_flag_o, irq_o;

    int    n_checks = 0, n_fail = 0;
    string phase = "R1";
    bit    done = 0;

    always #10 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_src_i(ext_src_i),
        .cnt_pin_i(cnt_pin_i), .ctl_pin_i(ctl_pin_i), .cap_mode_i(cap_mode_i),
        .ext_en_i(ext_en_i), .updn_en_i(updn_en_i), .cnt_wr_i(cnt_wr_i),
        .cnt_wdata_i(cnt_wdata_i), .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i),
        .ovf_clr_i(ovf_clr_i), .ext_clr_i(ext_clr_i), .cnt_o(cnt_o), .rld_o(rld_o),
        .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o), .irq_o(irq_o)
    );

    // behavioural reference model
    int unsigned m_cnt, m_rld;
    bit m_ovf, m_ext;
    bit qc[$], qx[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_ovf = 0; m_ext = 0;
            qc = '{0, 0}; qx = '{0, 0};
            qc.push_back(0); qx.push_back(0);
        end else begin
            bit fc, fx, up, stp, ev, xev, ud, frc;
            int unsigned nc, nr;
            fc = qc[2] && !qc[1];
            fx = qx[2] && !qx[1];
            up = qx[1];
            void'(qc.pop_back()); qc.push_front(cnt_pin_i);
            void'(qx.pop_back()); qx.push_front(ctl_pin_i);
            stp = ext_src_i ? fc : tick_i;
            ud  = !cap_mode_i && updn_en_i;
            frc = !cap_mode_i && !updn_en_i && ext_en_i && fx;
            ev = 0; xev = 0; nc = m_cnt; nr = m_rld;
            if (cnt_wr_i) nc = cnt_wdata_i;
            else if (frc) nc = m_rld;
            else if (stp) begin
                if (!ud || up) begin
                    if (m_cnt == 16'hFFFF) begin ev = 1; nc = cap_mode_i ? 0 : m_rld; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == m_rld) begin ev = 1; nc = 16'hFFFF; end
                    else nc = m_cnt - 1;
                end
            end
            if (cap_mode_i && ext_en_i && fx) begin xev = 1; nr = m_cnt; end
            if (frc) xev = 1;
            if (rld_wr_i) nr = rld_wdata_i;
            m_ovf = (m_ovf && !ovf_clr_i) || ev;
            if (ud) m_ext = (m_ext && !ext_clr_i) ^ ev;
            else    m_ext = (m_ext && !ext_clr_i) || xev;
            m_cnt = nc; m_rld = nr;
        end
    end

    always @(posedge clk) begin
        #5;
        if (rst_n && !done) begin
            bit [34:0] act, exp;
            bit eirq;
            eirq = m_ovf || (m_ext && !(!cap_mode_i && updn_en_i));
            act = {cnt_o, rld_o, ovf_flag_o, ext_flag_o, irq_o};
            exp = {m_cnt[15:0], m_rld[15:0], m_ovf, m_ext, eirq};
            n_checks++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s model compare act=%h exp=%h at %0t", phase, act, exp, $time);
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cnt(logic [15:0] v);
        cnt_wr_i = 1; cnt_wdata_i = v; cyc(1); cnt_wr_i = 0;
    endtask

    task automatic wr_rld(logic [15:0] v);
        rld_wr_i = 1; rld_wdata_i = v; cyc(1); rld_wr_i = 0;
    endtask

    initial begin
        logic [15:0] saved;
        cyc(3);
        rst_n = 1;
        // R1 reset state
        check("R1", {cnt_o, rld_o}, 32'h0);
        check("R1", {ovf_flag_o, ext_flag_o, irq_o}, 3'b000);

        phase = "R9";
        wr_cnt(16'h1234);
        check("R9", cnt_o, 16'h1234);
        wr_rld(16'hABCD);
        check("R9", rld_o, 16'hABCD);
        // write beats a tick in the same cycle
        tick_i = 1; cnt_wr_i = 1; cnt_wdata_i = 16'h0500; cyc(1);
        cnt_wr_i = 0; tick_i = 0;
        check("R9", cnt_o, 16'h0500);

        phase = "R3";
        wr_cnt(16'hFFFF);
        tick_i = 1; cyc(1); tick_i = 0;
        check("R3", {cnt_o, 15'b0, ovf_flag_o}, {16'h0000, 16'h0001});

        phase = "R8";
        ovf_clr_i = 1; cyc(1); ovf_clr_i = 0;
        check("R8", ovf_flag_o, 1'b0);
        wr_cnt(16'hFFFF);
        tick_i = 1; ovf_clr_i = 1; cyc(1); tick_i = 0; ovf_clr_i = 0;
        check("R8", ovf_flag_o, 1'b1);
        cyc(4);
        check("R8", ovf_flag_o, 1'b1);
        ovf_clr_i = 1; cyc(1); ovf_clr_i = 0;

        phase = "R2";
        for (int i = 0; i < 24; i++) begin tick_i = i[0]; cyc(1); end
        tick_i = 0;

        phase = "R4";
        ext_en_i = 1; tick_i = 1;
        ctl_pin_i = 0; cyc(5); ctl_pin_i = 1; cyc(4);
        check("R4", ext_flag_o, 1'b1);
        ext_clr_i = 1; cyc(1); ext_clr_i = 0;
        ext_en_i = 0; saved = rld_o;
        ctl_pin_i = 0; cyc(5); ctl_pin_i = 1; cyc(4);
        check("R4", {rld_o, 15'b0, ext_flag_o}, {saved, 16'h0000});

        phase = "R5";
        cap_mode_i = 0; ext_en_i = 1;
        wr_rld(16'h0100); wr_cnt(16'hFFF0);
        cyc(30);
        ctl_pin_i = 0; cyc(1); ctl_pin_i = 1; cyc(6);
        check("R5", ext_flag_o, 1'b1);
        ext_clr_i = 1; cyc(1); ext_clr_i = 0;

        phase = "R6";
        updn_en_i = 1; tick_i = 0;
        wr_rld(16'h0010); wr_cnt(16'hFFFC);
        tick_i = 1; cyc(10);
        ctl_pin_i = 0; tick_i = 0; cyc(4);
        wr_cnt(16'h0011);
        tick_i = 1; cyc(2); tick_i = 0;
        check("R6", {cnt_o, 15'b0, ovf_flag_o}, {16'hFFFF, 16'h0001});

        phase = "R7";
        check("R7", irq_o, 1'b1);
        ovf_clr_i = 1; cyc(1); ovf_clr_i = 0;
        check("R7", irq_o, ext_flag_o & 1'b0);
        tick_i = 1; cyc(20); tick_i = 0;
        ctl_pin_i = 1; cyc(4);

        phase = "R10";
        updn_en_i = 0; cap_mode_i = 1; ext_en_i = 0; ext_src_i = 1;
        wr_cnt(16'h0000);
        tick_i = 1; cyc(6);
        check("R2", cnt_o, 16'h0000);
        cnt_pin_i = 0; cyc(1); cnt_pin_i = 1; cyc(1);
        check("R10", cnt_o, 16'h0000);
        cyc(1);
        check("R10", cnt_o, 16'h0001);
        for (int i = 0; i < 40; i++) begin cnt_pin_i = (i % 3) != 0; cyc(1); end
        cnt_pin_i = 1; cyc(4);

        phase = "R6";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom;
            tick_i = r[0]; ext_src_i = r[1] & r[2]; cnt_pin_i = r[3];
            ctl_pin_i = (r[7:4] != 0) ? ctl_pin_i : ~ctl_pin_i;
            if (i % 500 == 0) begin cap_mode_i = r[8]; ext_en_i = r[9]; updn_en_i = r[10]; end
            cnt_wr_i = (r[15:11] == 0); cnt_wdata_i = r[19] ? 16'hFFF8 : r[31:16];
            rld_wr_i = (r[24:20] == 0); rld_wdata_i = {r[27:25], 13'h1FF0};
            ovf_clr_i = (r[29:28] == 0); ext_clr_i = (r[31:30] == 0);
            cyc(1);
        end
        cnt_wr_i = 0; rld_wr_i = 0; ovf_clr_i = 0; ext_clr_i = 0;
        cyc(2);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule